// File: doc/BRIEF.md
# Low-Power Mode and Wake-Reset Controller

This block sequences the power states of a small microcontroller core: normal execution, idle (core halted, oscillator running), stop (oscillator halted) and a supply-low back-up state in which the oscillator is blocked. It drives an oscillator enable, a core hold and a system reset pulse, and raises a one-cycle non-vectored wake interrupt. Software enters idle or stop through single-cycle request strobes. An interrupt from the priority logic leaves either low-power state through a programmable stabilization wait.

A bank of external wake pins is synchronized and glitch-filtered. While the chip is in stop, a filtered edge of either polarity on any of these pins does not resume execution. It raises the wake interrupt, then a fixed-length reset pulse, then the long reset wait. In run and idle the pins have no effect on this block. A supply-low flag takes the block to back-up from any state. The block leaves back-up only when the flag clears, and it then performs the long reset wait.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While rst_n is low, clk_en_o=1, core_hold_o=1, sys_rst_o=0 and wake_nmi_o=0. From the cycle rst_n rises, core_hold_o stays high for 2^RST_LOG cycles (default 65536) and then falls, which is the run state.
- R2: In run, a one-cycle stop_req_i enters stop (clk_en_o=0, core_hold_o=1). A one-cycle idle_req_i enters idle (clk_en_o=1, core_hold_o=1). When both are high in the same cycle, stop is taken.
- R3: stop_req_i and idle_req_i are ignored in every state other than run.
- R4: After two synchronizer stages, a pin level that lasts fewer than FILT_CYC cycles (default 2) is discarded. A level held for FILT_CYC cycles or more is accepted.
- R5: In stop, an accepted rising or falling edge on any pin makes wake_nmi_o high for exactly one cycle.
- R6: The cycle after wake_nmi_o, sys_rst_o goes high for exactly RST_PULSE_CYC cycles (default 4) with clk_en_o=1. Then core_hold_o stays high for 2^RST_LOG cycles before run.
- R7: Pin edges in run or idle produce no wake_nmi_o and no sys_rst_o, and they do not change the state.
- R8: irq_i in idle or stop starts a wait with clk_en_o=1 and core_hold_o=1, after which the block runs. The wait length is set by wait_sel_i: 0 gives 2^W0_LOG cycles, 1 gives 2^W1_LOG, 2 gives 2^W2_LOG and 3 gives 2^W3_LOG (defaults 256, 2048, 8192, 65536).
- R9: lvd_i high puts the block in back-up from any state within 3 cycles, with clk_en_o=0 and core_hold_o=1. Pin activity and requests have no effect in back-up.
- R10: When lvd_i falls, the block leaves back-up without a sys_rst_o pulse and holds the core for 2^RST_LOG cycles before run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | External wake pins, asynchronous |
| lvd_i | input | 1 | Supply-low comparator flag, asynchronous |
| irq_i | input | 1 | Vectored interrupt pending from priority logic |
| stop_req_i | input | 1 | Single-cycle request to enter stop |
| idle_req_i | input | 1 | Single-cycle request to enter idle |
| wait_sel_i | input | 2 | Stabilization wait select for interrupt wake |
| clk_en_o | output | 1 | Oscillator / clock enable |
| core_hold_o | output | 1 | Holds the core from executing |
| sys_rst_o | output | 1 | System reset pulse |
| wake_nmi_o | output | 1 | Non-vectored wake interrupt, one cycle |

## Verification
The assertions assume that irq_i and the request strobes are synchronous to clk and last one cycle. They also assume that pin_i and lvd_i may change at any time, but that only their synchronized values matter. The stimulus drives every input on the falling clock edge. Requests and interrupts are pulsed for exactly one cycle. Pin glitches are made one or more whole cycles wide, so the filter sees a known number of differing samples. The wait lengths are scaled down by parameter overrides so that each interval can be counted exactly.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

   typedef enum logic [2:0] {
      ST_RST_WAIT = 3'd0,
      ST_RUN      = 3'd1,
      ST_IDLE     = 3'd2,
      ST_STOP     = 3'd3,
      ST_WAKE     = 3'd4,
      ST_RPULSE   = 3'd5,
      ST_STAB     = 3'd6,
      ST_BACKUP   = 3'd7
   } pw_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wake_pin_filter.sv
module wake_pin_filter #(
   parameter int               NPINS    = 8,
   parameter int               FILT_CYC = 2,
   parameter logic [NPINS-1:0] PIN_IDLE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] raw_i,
   output logic             edge_o
);

   localparam int FCW = $clog2(FILT_CYC + 1);

   logic [NPINS-1:0] filt_q;
   logic [NPINS-1:0] prev_q;

   for (genvar gi = 0; gi < NPINS; gi++) begin : g_bit
      logic s1_q, s2_q, f_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= PIN_IDLE[gi];
            s2_q <= PIN_IDLE[gi];
         end else begin
            s1_q <= raw_i[gi];
            s2_q <= s1_q;
         end
      end

      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= PIN_IDLE[gi];
            else        f_q <= s2_q;
         end
      end else begin : g_count
         logic [FCW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q   <= PIN_IDLE[gi];
               cnt_q <= '0;
            end else if (s2_q == f_q) begin
               cnt_q <= '0;
            end else if (cnt_q == FCW'(FILT_CYC - 1)) begin
               f_q   <= s2_q;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end

      assign filt_q[gi] = f_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PIN_IDLE;
      else        prev_q <= filt_q;
   end

   assign edge_o = |(filt_q ^ prev_q);

endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
   parameter int            CW   = 16,
   parameter logic [CW-1:0] INIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          done_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= INIT;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwr_wake_pkg::*;
#(
   parameter int               NPINS         = 8,
   parameter int               FILT_CYC      = 2,
   parameter int               RST_PULSE_CYC = 4,
   parameter int               RST_LOG       = 16,
   parameter int               W0_LOG        = 8,
   parameter int               W1_LOG        = 11,
   parameter int               W2_LOG        = 13,
   parameter int               W3_LOG        = 16,
   parameter logic [NPINS-1:0] PIN_IDLE      = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_i,
   input  logic             lvd_i,
   input  logic             irq_i,
   input  logic             stop_req_i,
   input  logic             idle_req_i,
   input  logic [1:0]       wait_sel_i,
   output logic             clk_en_o,
   output logic             core_hold_o,
   output logic             sys_rst_o,
   output logic             wake_nmi_o
);

   localparam int CW = imax(imax(RST_LOG, imax(W0_LOG, W1_LOG)), imax(W2_LOG, W3_LOG));
   localparam logic [CW-1:0] RST_VAL   = CW'((64'd1 << RST_LOG) - 64'd1);
   localparam logic [CW-1:0] PULSE_VAL = CW'(RST_PULSE_CYC - 1);
   localparam logic [CW-1:0] STAB_TAB [4] = '{
      CW'((64'd1 << W0_LOG) - 64'd1),
      CW'((64'd1 << W1_LOG) - 64'd1),
      CW'((64'd1 << W2_LOG) - 64'd1),
      CW'((64'd1 << W3_LOG) - 64'd1)
   };

   if (NPINS < 1) begin : g_chk_pins
      $error("NPINS must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_chk_filt
      $error("FILT_CYC must be at least 1");
   end
   if (RST_PULSE_CYC < 1 || RST_PULSE_CYC > (1 << CW)) begin : g_chk_pulse
      $error("RST_PULSE_CYC out of range");
   end
   if (imax(RST_LOG, 0) > 24 || W0_LOG < 1 || W1_LOG < 1 || W2_LOG < 1 || W3_LOG < 1 || RST_LOG < 1) begin : g_chk_logs
      $error("wait exponents must lie in 1..24");
   end

   logic [1:0] lvd_sq;
   logic       lvd_s;
   logic       pin_edge;
   logic       t_load, t_done;
   logic [CW-1:0] t_val;
   pw_state_e  state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvd_sq <= '0;
      else        lvd_sq <= {lvd_sq[0], lvd_i};
   end
   assign lvd_s = lvd_sq[1];

   wake_pin_filter #(
      .NPINS   (NPINS),
      .FILT_CYC(FILT_CYC),
      .PIN_IDLE(PIN_IDLE)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (pin_i),
      .edge_o(pin_edge)
   );

   stab_timer #(
      .CW  (CW),
      .INIT(RST_VAL)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(t_load),
      .val_i (t_val),
      .done_o(t_done)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = RST_VAL;
      unique case (state_q)
         ST_RST_WAIT: if (t_done) state_d = ST_RUN;
         ST_RUN: begin
            if (stop_req_i)      state_d = ST_STOP;
            else if (idle_req_i) state_d = ST_IDLE;
         end
         ST_IDLE: if (irq_i) begin
            state_d = ST_STAB;
            t_load  = 1'b1;
            t_val   = STAB_TAB[wait_sel_i];
         end
         ST_STOP: begin
            if (pin_edge) begin
               state_d = ST_WAKE;
            end else if (irq_i) begin
               state_d = ST_STAB;
               t_load  = 1'b1;
               t_val   = STAB_TAB[wait_sel_i];
            end
         end
         ST_WAKE: begin
            state_d = ST_RPULSE;
            t_load  = 1'b1;
            t_val   = PULSE_VAL;
         end
         ST_RPULSE: if (t_done) begin
            state_d = ST_RST_WAIT;
            t_load  = 1'b1;
         end
         ST_STAB: if (t_done) state_d = ST_RUN;
         ST_BACKUP: if (!lvd_s) begin
            state_d = ST_RST_WAIT;
            t_load  = 1'b1;
         end
         default: state_d = ST_RST_WAIT;
      endcase
      if (lvd_s) begin
         state_d = ST_BACKUP;
         t_load  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RST_WAIT;
      else        state_q <= state_d;
   end

   always_comb begin
      clk_en_o    = 1'b1;
      core_hold_o = 1'b1;
      sys_rst_o   = 1'b0;
      wake_nmi_o  = 1'b0;
      unique case (state_q)
         ST_RUN:    core_hold_o = 1'b0;
         ST_STOP:   clk_en_o    = 1'b0;
         ST_BACKUP: clk_en_o    = 1'b0;
         ST_WAKE:   wake_nmi_o  = 1'b1;
         ST_RPULSE: sys_rst_o   = 1'b1;
         default:   ;
      endcase
   end

endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
   parameter int RST_PULSE_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic clk_en_o,
   input logic core_hold_o,
   input logic sys_rst_o,
   input logic wake_nmi_o,
   input logic lvd_s
);

   int unsigned rst_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rst_len_q <= 0;
      else if (sys_rst_o) rst_len_q <= rst_len_q + 1;
      else                rst_len_q <= 0;
   end

   AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_nmi_o |=> !wake_nmi_o); // R5
   AST_NMI_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_nmi_o |-> $past(!clk_en_o && core_hold_o)); // R5
   AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      wake_nmi_o |=> sys_rst_o); // R6
   AST_RST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> (rst_len_q == RST_PULSE_CYC)); // R6
   AST_RST_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> (clk_en_o && core_hold_o)); // R6
   AST_HOLD_WHEN_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_o |-> core_hold_o); // R2
   AST_BACKUP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lvd_s) && lvd_s) |-> (!clk_en_o && core_hold_o && !wake_nmi_o)); // R9

endmodule

bind pwr_wake_ctrl pwr_wake_chk #(
   .RST_PULSE_CYC(RST_PULSE_CYC)
) u_pwr_wake_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en_o   (clk_en_o),
   .core_hold_o(core_hold_o),
   .sys_rst_o  (sys_rst_o),
   .wake_nmi_o (wake_nmi_o),
   .lvd_s      (lvd_s)
);

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;

   localparam int RST_N = 256;   // 2^RST_LOG with RST_LOG = 8

   // mode (0 idle, 1 stop), wait select, expected hold cycles (W logs 3,4,5,6)
   localparam int VEC [8][3] = '{
      '{0, 0, 8}, '{0, 1, 16}, '{0, 2, 32}, '{0, 3, 64},
      '{1, 3, 64}, '{1, 2, 32}, '{1, 1, 16}, '{1, 0, 8}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin = 8'hFF;
   logic       lvd = 1'b0, irq = 1'b0, stop_req = 1'b0, idle_req = 1'b0;
   logic [1:0] wait_sel = 2'd0;
   logic       clk_en, core_hold, sys_rst, wake_nmi;

   int vec_cnt = 0;
   int err_cnt = 0;
   int nmi_tot = 0;
   int rst_tot = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   pwr_wake_ctrl #(
      .NPINS(8), .FILT_CYC(2), .RST_PULSE_CYC(4), .RST_LOG(8),
      .W0_LOG(3), .W1_LOG(4), .W2_LOG(5), .W3_LOG(6)
   ) i_pwr_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .lvd_i(lvd), .irq_i(irq),
      .stop_req_i(stop_req), .idle_req_i(idle_req), .wait_sel_i(wait_sel),
      .clk_en_o(clk_en), .core_hold_o(core_hold), .sys_rst_o(sys_rst),
      .wake_nmi_o(wake_nmi)
   );

   always @(negedge clk) begin
      if (rst_n && wake_nmi) nmi_tot++;
      if (rst_n && sys_rst)  rst_tot++;
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         err_cnt++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vec_cnt++;
      if (act != exp) begin
         err_cnt++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold_len(output int n);
      n = 0;
      while (core_hold && n < 70000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic pulse_idle();
      idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
   endtask

   task automatic pulse_irq();
      irq = 1'b1; @(negedge clk); irq = 1'b0;
   endtask

   task automatic wait_run();
      for (int i = 0; i < 70000 && core_hold; i++) @(negedge clk);
   endtask

   task automatic reset_path(input string req);
      int n, w;
      n = 0;
      for (int i = 0; i < 60 && !sys_rst; i++) @(negedge clk);
      while (sys_rst && n < 100) begin n++; @(negedge clk); end
      chk({req, " reset pulse width"}, n, 4);
      hold_len(w);
      chk({req, " reset wait"}, w, RST_N);
   endtask

   initial begin
      int n, nb, rb;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 clk_en in reset", int'(clk_en), 1);
      chk("R1 hold in reset", int'(core_hold), 1);
      chk("R1 rst/nmi in reset", int'(sys_rst) + int'(wake_nmi), 0);
      rst_n = 1'b1;
      hold_len(n);
      chk("R1 reset wait length", n, RST_N);

      // R2 R8 table walk
      for (int v = 0; v < 8; v++) begin
         wait_sel = VEC[v][1][1:0];
         if (VEC[v][0] == 1) pulse_stop(); else pulse_idle();
         chk("R2 clk_en after request", int'(clk_en), (VEC[v][0] == 1) ? 0 : 1);
         chk("R2 hold after request", int'(core_hold), 1);
         repeat (3) @(negedge clk);
         pulse_irq();
         hold_len(n);
         chk("R8 wake wait length", n, VEC[v][2]);
      end

      // R2 both requests: stop wins; R3 idle request in stop ignored
      stop_req = 1'b1; idle_req = 1'b1; @(negedge clk);
      stop_req = 1'b0; idle_req = 1'b0;
      chk("R2 stop wins over idle", int'(clk_en), 0);
      pulse_idle(); repeat (2) @(negedge clk);
      chk("R3 idle request in stop ignored", int'(clk_en), 0);
      wait_sel = 2'd0; pulse_irq(); hold_len(n);
      chk("R8 stop wake sel0", n, 8);

      // R3 stop request in idle ignored; R7 pins in idle
      pulse_idle();
      pulse_stop(); repeat (2) @(negedge clk);
      chk("R3 stop request in idle ignored", int'(clk_en), 1);
      nb = nmi_tot; rb = rst_tot;
      pin[2] = 1'b0; repeat (6) @(negedge clk); pin[2] = 1'b1; repeat (8) @(negedge clk);
      chk("R7 idle pins no nmi/reset", (nmi_tot - nb) + (rst_tot - rb), 0);
      chk("R7 idle kept", int'(clk_en) + int'(core_hold), 2);
      wait_sel = 2'd1; pulse_irq(); hold_len(n);
      chk("R7 still idle, irq wake", n, 16);

      // R7 pins in run
      pin[6] = 1'b0; repeat (6) @(negedge clk); pin[6] = 1'b1; repeat (8) @(negedge clk);
      chk("R7 run pins no nmi/reset", (nmi_tot - nb) + (rst_tot - rb), 0);
      chk("R7 run kept", int'(core_hold), 0);

      // R4 glitch in stop ignored, then R5 R6 accepted falling edge
      pulse_stop();
      pin[0] = 1'b0; @(negedge clk); pin[0] = 1'b1;
      repeat (10) @(negedge clk);
      chk("R4 short pulse ignored", nmi_tot - nb, 0);
      chk("R4 still in stop", int'(clk_en), 0);
      pin[7] = 1'b0; repeat (2) @(negedge clk); pin[7] = 1'b1;
      reset_path("R6 falling edge");
      chk("R5 one nmi cycle on falling edge", nmi_tot - nb, 1);
      chk("R4 two-cycle pulse accepted", rst_tot - rb, 4);

      // R5 rising edge
      pin[5] = 1'b0; repeat (8) @(negedge clk);
      pulse_stop(); repeat (3) @(negedge clk);
      nb = nmi_tot;
      pin[5] = 1'b1;
      reset_path("R6 rising edge");
      chk("R5 one nmi cycle on rising edge", nmi_tot - nb, 1);

      // R9 R10 back-up from run
      nb = nmi_tot; rb = rst_tot;
      lvd = 1'b1; repeat (4) @(negedge clk);
      chk("R9 backup clk_en off", int'(clk_en), 0);
      chk("R9 backup hold", int'(core_hold), 1);
      pin[1] = 1'b0; pulse_stop(); pulse_idle(); repeat (6) @(negedge clk);
      pin[1] = 1'b1; pulse_irq(); repeat (6) @(negedge clk);
      chk("R9 backup ignores pins", (nmi_tot - nb) + int'(clk_en), 0);
      lvd = 1'b0;
      for (int i = 0; i < 20 && !clk_en; i++) @(negedge clk);
      hold_len(n);
      chk("R10 backup exit wait", n, RST_N);
      chk("R10 no reset pulse", rst_tot - rb, 0);

      // R9 priority during a stabilization wait
      wait_sel = 2'd3; pulse_idle(); pulse_irq();
      repeat (5) @(negedge clk);
      lvd = 1'b1; repeat (4) @(negedge clk);
      chk("R9 backup beats wait", int'(clk_en), 0);
      lvd = 1'b0;
      for (int i = 0; i < 20 && !clk_en; i++) @(negedge clk);
      hold_len(n);
      chk("R10 exit after interrupted wait", n, RST_N);

      wait_run();
      summary();
      $finish;
   end

endmodule